// File: doc/BRIEF.md
# Pass-Through Target Handshake Bridge

This block joins a simplified bus-target port to a local add-on register port so that add-on logic can answer bus cycles directly, one data word at a time. When a bus cycle is requested and one of the region-hit lines is set, the bridge latches the cycle address into a read-only address register and drives an active-low attention line toward the add-on side. It then holds the bus in wait states. A bus write finishes when the add-on reads the data register. A bus read finishes when the add-on writes the data register, and the written word goes back as read data. If the initiator abandons the cycle, the bridge drops attention and returns to idle without completing anything.

The add-on side sees two 32-bit registers: the captured address at byte offset 28h, which is read-only, and the data word at byte offset 2Ch, which is read/write. It also sees the index of the region that was hit and the direction of the pending cycle, so its own decode can work out how to respond. Address decoding, configuration space and electrical signalling stay outside the block. Region hits arrive already decoded as a one-hot vector.

Top module: `ptb_bridge`

## Requirements
- R1: On a hit accepted from idle, the add-on read of offset 28h returns the captured bus address from the next cycle onward.
- R2: `attn_n` goes low in the cycle after an accepted hit and stays low while the cycle is pending. It is high whenever no cycle is pending.
- R3: `cyc_ready` stays low during every wait cycle and is high for exactly one cycle per completed transfer.
- R4: For a bus write, the bus write data is captured at the hit. A read of offset 2Ch by the add-on while the cycle is pending completes it, with `cyc_ready` high in the next cycle. That read returns the captured word.
- R5: For a bus read, a write of offset 2Ch by the add-on while the cycle is pending completes it, with `cyc_ready` high in the next cycle. `cyc_rdata` equals the written word while `cyc_ready` is high and is zero otherwise.
- R6: If `cyc_abort` is high while a cycle is pending, `attn_n` returns high in the next cycle and no `cyc_ready` pulse is given for that cycle. Abort takes priority over a completing add-on access in the same cycle.
- R7: The address register is read-only: an add-on write to offset 28h leaves its contents unchanged.
- R8: The data register is read/write: outside a completing cycle, an add-on write to offset 2Ch is returned by later reads of 2Ch. Reads of any other offset return zero.
- R9: `ao_region` gives the hit region as a binary index, where regions 1 to 4 are bits 0 to 3 of `cyc_hit` and map to index 0 to 3. If several bits are set, the lowest one wins. `ao_dir_write` is 1 for a bus write and 0 for a bus read.
- R10: A new hit is ignored while a cycle is pending or completing. `attn_n` is already high in the cycle where `cyc_ready` is high.
- R11: No cycle starts unless `cyc_req` is high and at least one bit of `cyc_hit` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| cyc_req | input | 1 | Bus target cycle requested |
| cyc_hit | input | 4 | Region-hit lines, bit n for region n+1 |
| cyc_addr | input | 32 | Address of the current bus cycle |
| cyc_write | input | 1 | 1 for a bus write, 0 for a bus read |
| cyc_wdata | input | 32 | Bus write data |
| cyc_abort | input | 1 | Initiator abandons the pending cycle |
| cyc_ready | output | 1 | One-cycle completion strobe to the bus (low means wait) |
| cyc_rdata | output | 32 | Read data returned with the strobe |
| ao_addr | input | 8 | Add-on register byte offset |
| ao_rd | input | 1 | Add-on register read strobe |
| ao_wr | input | 1 | Add-on register write strobe |
| ao_wdata | input | 32 | Add-on write data |
| ao_rdata | output | 32 | Add-on read data for the addressed register |
| attn_n | output | 1 | Active-low attention to the add-on side |
| ao_region | output | 2 | Index of the hit region |
| ao_dir_write | output | 1 | Direction of the pending cycle |

## Verification
A stuck or wrong control state shows up at the ports within one clock. `attn_n` and `cyc_ready` are both decoded straight from the state, so a missed completion, a lost abort or a hit accepted during a pending cycle shows as an attention or strobe level that differs from the model in the very next cycle. A wrong address or data latch stays hidden until the add-on reads 28h or 2Ch, or until the read strobe returns `cyc_rdata`. For that reason the bench reads both registers inside every scenario and compares all outputs on every clock.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

   typedef enum logic [1:0] {
      PT_IDLE = 2'd0,
      PT_WAIT = 2'd1,
      PT_DONE = 2'd2
   } pt_state_e;

endpackage

// File: rtl/ptb_ctrl.sv
module ptb_ctrl
   import ptb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_req,
   input  logic hit_any,
   input  logic cyc_write,
   input  logic cyc_abort,
   input  logic ao_rd_data,
   input  logic ao_wr_data,
   output logic capture,
   output logic pending,
   output logic done,
   output logic dir_write_q
);

   pt_state_e state_q, state_d;
   logic      finish;

   assign capture = (state_q == PT_IDLE) && cyc_req && hit_any;
   assign finish  = (state_q == PT_WAIT) && !cyc_abort &&
                    (dir_write_q ? ao_rd_data : ao_wr_data);

   always_comb begin
      state_d = state_q;
      case (state_q)
         PT_IDLE: if (capture) state_d = PT_WAIT;
         PT_WAIT: begin
            if (cyc_abort)   state_d = PT_IDLE;
            else if (finish) state_d = PT_DONE;
         end
         PT_DONE: state_d = PT_IDLE;
         default: state_d = PT_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= PT_IDLE;
         dir_write_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (capture) dir_write_q <= cyc_write;
      end
   end

   assign pending = (state_q == PT_WAIT);
   assign done    = (state_q == PT_DONE);

endmodule

// File: rtl/ptb_regs.sv
module ptb_regs #(
   parameter int          W        = 32,
   parameter int          NREG     = 4,
   parameter int          OFS_W    = 8,
   parameter logic [7:0]  ADDR_OFS = 8'h28,
   parameter logic [7:0]  DATA_OFS = 8'h2C,
   localparam int         IW       = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             capture,
   input  logic [NREG-1:0]  cyc_hit,
   input  logic [W-1:0]     cyc_addr,
   input  logic             cyc_write,
   input  logic [W-1:0]     cyc_wdata,
   input  logic [OFS_W-1:0] ao_addr,
   input  logic             ao_wr,
   input  logic [W-1:0]     ao_wdata,
   output logic [W-1:0]     addr_q,
   output logic [W-1:0]     data_q,
   output logic [IW-1:0]    region_q,
   output logic [W-1:0]     ao_rdata
);

   localparam logic [OFS_W-1:0] A_OFS = OFS_W'(ADDR_OFS);
   localparam logic [OFS_W-1:0] D_OFS = OFS_W'(DATA_OFS);

   // lowest-index priority select over the hit lines
   logic [NREG-1:0] below_set;
   logic [NREG-1:0] first_hit;
   logic [IW-1:0]   hit_idx;

   genvar gi;
   for (gi = 0; gi < NREG; gi++) begin : g_prio
      if (gi == 0) begin : g_first
         assign below_set[gi] = 1'b0;
      end else begin : g_rest
         assign below_set[gi] = below_set[gi-1] | cyc_hit[gi-1];
      end
      assign first_hit[gi] = cyc_hit[gi] & ~below_set[gi];
   end

   always_comb begin
      hit_idx = '0;
      for (int k = 0; k < NREG; k++) begin
         if (first_hit[k]) hit_idx = hit_idx | IW'(k);
      end
   end

   always_ff @(posedge clk) begin
      if (capture) begin
         addr_q   <= cyc_addr;
         region_q <= hit_idx;
      end
      if (capture && cyc_write)
         data_q <= cyc_wdata;
      else if (ao_wr && ao_addr == D_OFS)
         data_q <= ao_wdata;
   end

   always_comb begin
      if (ao_addr == A_OFS)      ao_rdata = addr_q;
      else if (ao_addr == D_OFS) ao_rdata = data_q;
      else                       ao_rdata = '0;
   end

endmodule

// File: rtl/ptb_bridge.sv
module ptb_bridge #(
   parameter int          W        = 32,
   parameter int          NREG     = 4,
   parameter int          OFS_W    = 8,
   parameter logic [7:0]  ADDR_OFS = 8'h28,
   parameter logic [7:0]  DATA_OFS = 8'h2C,
   localparam int         IW       = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_req,
   input  logic [NREG-1:0]  cyc_hit,
   input  logic [W-1:0]     cyc_addr,
   input  logic             cyc_write,
   input  logic [W-1:0]     cyc_wdata,
   input  logic             cyc_abort,
   output logic             cyc_ready,
   output logic [W-1:0]     cyc_rdata,
   input  logic [OFS_W-1:0] ao_addr,
   input  logic             ao_rd,
   input  logic             ao_wr,
   input  logic [W-1:0]     ao_wdata,
   output logic [W-1:0]     ao_rdata,
   output logic             attn_n,
   output logic [IW-1:0]    ao_region,
   output logic             ao_dir_write
);

   if (NREG < 2) begin : g_bad_nreg
      $error("ptb_bridge: NREG must be at least 2");
   end
   if (OFS_W < 1 || OFS_W > 8) begin : g_bad_ofs
      $error("ptb_bridge: OFS_W must be 1 to 8");
   end
   if (ADDR_OFS == DATA_OFS) begin : g_same_ofs
      $error("ptb_bridge: register offsets must differ");
   end
   if (W < 1) begin : g_bad_w
      $error("ptb_bridge: W must be positive");
   end

   localparam logic [OFS_W-1:0] D_OFS = OFS_W'(DATA_OFS);

   logic          capture, pending, done, dir_write_q;
   logic          ao_rd_data, ao_wr_data;
   logic [W-1:0]  addr_q, data_q;
   logic [IW-1:0] region_q;

   assign ao_rd_data = ao_rd && (ao_addr == D_OFS);
   assign ao_wr_data = ao_wr && (ao_addr == D_OFS);

   ptb_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_req     (cyc_req),
      .hit_any     (|cyc_hit),
      .cyc_write   (cyc_write),
      .cyc_abort   (cyc_abort),
      .ao_rd_data  (ao_rd_data),
      .ao_wr_data  (ao_wr_data),
      .capture     (capture),
      .pending     (pending),
      .done        (done),
      .dir_write_q (dir_write_q)
   );

   ptb_regs #(
      .W        (W),
      .NREG     (NREG),
      .OFS_W    (OFS_W),
      .ADDR_OFS (ADDR_OFS),
      .DATA_OFS (DATA_OFS)
   ) u_regs (
      .clk       (clk),
      .capture   (capture),
      .cyc_hit   (cyc_hit),
      .cyc_addr  (cyc_addr),
      .cyc_write (cyc_write),
      .cyc_wdata (cyc_wdata),
      .ao_addr   (ao_addr),
      .ao_wr     (ao_wr),
      .ao_wdata  (ao_wdata),
      .addr_q    (addr_q),
      .data_q    (data_q),
      .region_q  (region_q),
      .ao_rdata  (ao_rdata)
   );

   assign attn_n       = !pending;
   assign cyc_ready    = done;
   assign cyc_rdata    = (done && !dir_write_q) ? data_q : '0;
   assign ao_region    = region_q;
   assign ao_dir_write = dir_write_q;

endmodule

// File: rtl/ptb_bridge_chk.sv
module ptb_bridge_chk #(
   parameter int W    = 32,
   parameter int NREG = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cyc_req,
   input logic [NREG-1:0] cyc_hit,
   input logic [W-1:0]    cyc_addr,
   input logic            cyc_abort,
   input logic            cyc_ready,
   input logic            attn_n,
   input logic [W-1:0]    addr_q
);

   logic past_ok;
   logic idle_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign idle_hit = attn_n && !cyc_ready && cyc_req && (|cyc_hit);

   // R2
   attn_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_hit |=> !attn_n);

   // R1
   addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_hit |=> (addr_q == $past(cyc_addr)));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !idle_hit) |=> $stable(addr_q));

   // R3
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ready |=> !cyc_ready);

   // R10
   ready_attn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ready |-> attn_n);

   // R10
   ready_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && cyc_ready) |-> !$past(attn_n));

   // R6
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!attn_n && cyc_abort) |=> (attn_n && !cyc_ready));

endmodule

bind ptb_bridge ptb_bridge_chk #(.W(W), .NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cyc_req   (cyc_req),
   .cyc_hit   (cyc_hit),
   .cyc_addr  (cyc_addr),
   .cyc_abort (cyc_abort),
   .cyc_ready (cyc_ready),
   .attn_n    (attn_n),
   .addr_q    (addr_q)
);

// File: tb/ptb_bridge_bench.sv
`timescale 1ns/1ps
module ptb_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cyc_req, cyc_write, cyc_abort;
   logic [3:0]  cyc_hit;
   logic [31:0] cyc_addr, cyc_wdata;
   logic        cyc_ready;
   logic [31:0] cyc_rdata;
   logic [7:0]  ao_addr;
   logic        ao_rd, ao_wr;
   logic [31:0] ao_wdata, ao_rdata;
   logic        attn_n;
   logic [1:0]  ao_region;
   logic        ao_dir_write;

   int tests = 0;
   int fails = 0;

   // behavioural reference state
   int          m_state = 0;   // 0 idle, 1 waiting, 2 strobe
   logic [31:0] m_addr = '0, m_data = '0;
   int          m_region = 0;
   bit          m_dirw = 1'b0;
   bit          m_addr_ok = 1'b0, m_data_ok = 1'b0;

   always #5 clk = ~clk;

   ptb_bridge u_ptb_bridge (
      .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_hit(cyc_hit),
      .cyc_addr(cyc_addr), .cyc_write(cyc_write), .cyc_wdata(cyc_wdata),
      .cyc_abort(cyc_abort), .cyc_ready(cyc_ready), .cyc_rdata(cyc_rdata),
      .ao_addr(ao_addr), .ao_rd(ao_rd), .ao_wr(ao_wr), .ao_wdata(ao_wdata),
      .ao_rdata(ao_rdata), .attn_n(attn_n), .ao_region(ao_region),
      .ao_dir_write(ao_dir_write)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int lowest(input logic [3:0] h);
      for (int i = 3; i >= 0; i--) if (h[i]) lowest = i;
   endfunction

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // one clock: advance the model at the edge, compare at the falling edge
   task automatic tick();
      int  nxt;
      bit  cap;
      logic [31:0] e_ao, e_rd;
      @(posedge clk);
      if (!rst_n) begin
         m_state = 0;
         m_dirw  = 1'b0;
      end else begin
         cap = (m_state == 0) && cyc_req && (cyc_hit != 4'b0);
         nxt = m_state;
         if (cap) nxt = 1;
         else if (m_state == 1) begin
            if (cyc_abort) nxt = 0;
            else if (m_dirw ? (ao_rd && ao_addr == 8'h2C)
                            : (ao_wr && ao_addr == 8'h2C)) nxt = 2;
         end else if (m_state == 2) nxt = 0;
         if (cap) begin
            m_addr = cyc_addr; m_region = lowest(cyc_hit);
            m_dirw = cyc_write; m_addr_ok = 1'b1;
         end
         if (cap && cyc_write) begin
            m_data = cyc_wdata; m_data_ok = 1'b1;
         end else if (ao_wr && ao_addr == 8'h2C) begin
            m_data = ao_wdata; m_data_ok = 1'b1;
         end
         m_state = nxt;
      end
      @(negedge clk);
      chk(attn_n == (m_state != 1), "R2 attn_n", {31'b0, attn_n}, {31'b0, m_state != 1});
      chk(cyc_ready == (m_state == 2), "R3 cyc_ready", {31'b0, cyc_ready}, {31'b0, m_state == 2});
      e_rd = (m_state == 2 && !m_dirw) ? m_data : 32'h0;
      if (m_data_ok) chk(cyc_rdata == e_rd, "R5 cyc_rdata", cyc_rdata, e_rd);
      if (ao_rd) begin
         if (ao_addr == 8'h28 && m_addr_ok) begin
            e_ao = m_addr; chk(ao_rdata == e_ao, "R1 ao_rdata addr", ao_rdata, e_ao);
         end else if (ao_addr == 8'h2C && m_data_ok) begin
            e_ao = m_data; chk(ao_rdata == e_ao, "R8 ao_rdata data", ao_rdata, e_ao);
         end else if (ao_addr != 8'h28 && ao_addr != 8'h2C) begin
            chk(ao_rdata == 32'h0, "R8 ao_rdata other", ao_rdata, 32'h0);
         end
      end
      if (m_addr_ok) begin
         chk(ao_region == 2'(m_region), "R9 ao_region", {30'b0, ao_region}, 32'(m_region));
         chk(ao_dir_write == m_dirw, "R9 ao_dir_write", {31'b0, ao_dir_write}, {31'b0, m_dirw});
      end
   endtask

   task automatic ao_access(input bit wr, input logic [7:0] ofs, input logic [31:0] val);
      ao_addr = ofs; ao_wdata = val; ao_wr = wr; ao_rd = !wr;
      tick();
      ao_wr = 1'b0; ao_rd = 1'b0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
   end

   initial begin
      rst_n = 1'b0; cyc_req = 0; cyc_hit = '0; cyc_addr = '0; cyc_write = 0;
      cyc_wdata = '0; cyc_abort = 0; ao_addr = '0; ao_rd = 0; ao_wr = 0; ao_wdata = '0;
      repeat (3) tick();
      chk(attn_n == 1'b1, "R2 reset attn_n", {31'b0, attn_n}, 32'h1);
      chk(cyc_ready == 1'b0, "R3 reset ready", {31'b0, cyc_ready}, 32'h0);
      rst_n = 1'b1;
      tick();

      // R8: data register read/write outside any cycle; other offsets read zero
      ao_access(1, 8'h2C, 32'hA5A5_0F0F);
      ao_access(0, 8'h2C, 32'h0);
      chk(ao_rdata == 32'hA5A5_0F0F, "R8 data readback", ao_rdata, 32'hA5A5_0F0F);
      ao_access(0, 8'h14, 32'h0);

      // R11: no start without request or without a region bit
      cyc_req = 0; cyc_hit = 4'b1111; cyc_addr = 32'h7777_0000; tick();
      chk(attn_n == 1'b1, "R11 no req", {31'b0, attn_n}, 32'h1);
      cyc_req = 1; cyc_hit = 4'b0000; tick();
      chk(attn_n == 1'b1, "R11 no hit", {31'b0, attn_n}, 32'h1);

      // R4: bus write to region 2
      cyc_hit = 4'b0010; cyc_addr = 32'h1000_0040; cyc_write = 1; cyc_wdata = 32'hDEAD_BEEF;
      tick();
      chk(attn_n == 1'b0, "R2 attn after hit", {31'b0, attn_n}, 32'h0);
      chk(ao_region == 2'd1, "R9 region 2", {30'b0, ao_region}, 32'h1);
      chk(ao_dir_write == 1'b1, "R9 dir write", {31'b0, ao_dir_write}, 32'h1);
      repeat (3) tick();
      chk(cyc_ready == 1'b0, "R3 wait states", {31'b0, cyc_ready}, 32'h0);
      ao_access(0, 8'h28, 32'h0);
      chk(ao_rdata == 32'h1000_0040, "R1 captured addr", ao_rdata, 32'h1000_0040);
      // R10: a fresh hit while pending is ignored
      cyc_hit = 4'b1000; cyc_addr = 32'h2222_2222; cyc_write = 0; tick();
      // R7: writing the address register has no effect
      ao_access(1, 8'h28, 32'h5555_5555);
      ao_access(0, 8'h28, 32'h0);
      chk(ao_rdata == 32'h1000_0040, "R7 R10 addr unchanged", ao_rdata, 32'h1000_0040);
      ao_addr = 8'h2C; ao_rd = 1; tick();
      chk(cyc_ready == 1'b1, "R4 ready after add-on read", {31'b0, cyc_ready}, 32'h1);
      chk(attn_n == 1'b1, "R10 attn high with ready", {31'b0, attn_n}, 32'h1);
      chk(ao_rdata == 32'hDEAD_BEEF, "R4 write data", ao_rdata, 32'hDEAD_BEEF);
      chk(cyc_rdata == 32'h0, "R5 rdata zero on write", cyc_rdata, 32'h0);
      ao_rd = 0; cyc_req = 0; cyc_hit = '0; tick();
      chk(cyc_ready == 1'b0, "R3 single pulse", {31'b0, cyc_ready}, 32'h0);

      // R5: bus read to region 4
      cyc_req = 1; cyc_hit = 4'b1000; cyc_addr = 32'h3000_0100; cyc_write = 0; tick();
      chk(ao_region == 2'd3, "R9 region 4", {30'b0, ao_region}, 32'h3);
      chk(ao_dir_write == 1'b0, "R9 dir read", {31'b0, ao_dir_write}, 32'h0);
      tick();
      ao_addr = 8'h2C; ao_wdata = 32'h1234_5678; ao_wr = 1; tick();
      chk(cyc_ready == 1'b1, "R5 ready after add-on write", {31'b0, cyc_ready}, 32'h1);
      chk(cyc_rdata == 32'h1234_5678, "R5 read data", cyc_rdata, 32'h1234_5678);
      ao_wr = 0; cyc_req = 0; cyc_hit = '0; tick();

      // R6: abort beats a completing read in the same cycle
      cyc_req = 1; cyc_hit = 4'b0001; cyc_addr = 32'h4000_0008; cyc_write = 1;
      cyc_wdata = 32'hCAFE_0001; tick();
      tick();
      cyc_abort = 1; ao_addr = 8'h2C; ao_rd = 1; tick();
      chk(attn_n == 1'b1, "R6 attn released", {31'b0, attn_n}, 32'h1);
      chk(cyc_ready == 1'b0, "R6 no ready", {31'b0, cyc_ready}, 32'h0);
      cyc_abort = 0; ao_rd = 0; cyc_req = 0; cyc_hit = '0; tick();
      chk(cyc_ready == 1'b0, "R6 no late ready", {31'b0, cyc_ready}, 32'h0);

      // R9: several region bits, lowest wins
      cyc_req = 1; cyc_hit = 4'b0110; cyc_addr = 32'h5000_0000; cyc_write = 0; tick();
      chk(ao_region == 2'd1, "R9 lowest hit", {30'b0, ao_region}, 32'h1);
      cyc_req = 0; cyc_hit = '0;
      ao_access(1, 8'h2C, 32'h0BAD_F00D);
      chk(cyc_rdata == 32'h0BAD_F00D, "R5 second read", cyc_rdata, 32'h0BAD_F00D);
      repeat (2) tick();

      summary();
   end

endmodule